// File: doc/BRIEF.md
# Register-Window SPI Command Engine

This block is a SPI master that runs one flash-style transaction at a time, set up through a small window of byte-wide registers. Software loads a command byte into a register of its own, writes a packed byte holding the receive and transmit counts, and fills an eight-entry data FIFO through a single data port. It then sets an execute bit. The engine lowers chip select and sends the command byte. It then sends the transmit bytes from the FIFO and clocks in the receive bytes.

Received bytes land in the same FIFO, directly after the transmitted ones. Software therefore resets the FIFO pointer and skips the transmit bytes before it collects the reply. Completion is seen either as the execute bit clearing itself or as the busy flag dropping. The serial side uses SPI mode 0 with a fixed clock divider.

Top module: `spi_cmd_engine`

## Requirements
- R1: The command byte is held at address 0x0 and is always the first byte shifted out. It is never taken from the FIFO. All bytes go out MSB first.
- R2: The count register at address 0x1 holds the receive count in bits 7:4 and the transmit count in bits 3:0. The transmit count does not include the command byte. A transmit count above the FIFO depth is treated as the FIFO depth. Both registers read back as written.
- R3: Writing a control byte to address 0x2 with bit 0 set, while idle, starts a transaction. Bit 0 of address 0x2 reads 1 until the transaction ends and then clears by itself. Bit 7 of address 0x3 reads 1 while the shifter is active. All other bits of these two addresses read 0.
- R4: Writing address 0x2 with bit 4 set clears the FIFO pointer. The pointer reads back in bits 2:0 of address 0xD, with the upper bits 0.
- R5: Each read or write of the data port at address 0xC accesses the FIFO entry at the pointer and then increments the pointer. The pointer wraps modulo 8. Any address not listed in R1 to R5 reads 0.
- R6: A transaction sends the command byte, then transmit bytes taken from FIFO entries 0 upward, then receive bytes with MOSI held low. Receive byte j is stored in FIFO entry (transmit count + j) mod 8. The software pointer is left unchanged.
- R7: When the transmit count is 0, one byte fewer than the receive field is received. A receive field of 0 then gives no receive bytes.
- R8: SCLK idles low. Each SCLK half period lasts CLK_DIV clocks. MISO is sampled at the rising edge, and MOSI changes only while SCLK is low. Chip select is low for exactly 16·CLK_DIV·(1 + transmit bytes + receive bytes) clocks, starting on the clock after the execute write.
- R9: While busy, writes to addresses 0x0, 0x1 and 0xC are ignored, and so is a further execute request. An ignored data-port write does not move the pointer.
- R10: A synchronous active-high reset clears the command, count, FIFO and pointer, clears busy, raises chip select and lowers SCLK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| regAddr | input | 4 | Register address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdEn | input | 1 | Register read strobe; a read of the data port advances the pointer |
| regRdData | output | 8 | Read data for regAddr, valid in the same cycle |
| spiCsN | output | 1 | Chip select, active low |
| spiSclk | output | 1 | Serial clock |
| spiMosi | output | 1 | Serial data out |
| spiMiso | input | 1 | Serial data in |

## Verification
The bench builds the engine with CLK_DIV set to 2 and the FIFO depth left at 8. The short half period keeps even a clamped ten-byte transaction to a few hundred clocks, so every count corner fits in one run. These corners are full transmit, zero transmit with the off-by-one receive count, an over-depth transmit field, and receive bytes wrapping past entry 7 back to entry 0. The depth of 8 makes the pointer wrap after eight data-port accesses and puts that wrap within reach.

// File: rtl/spi_cmd_pkg.sv
`timescale 1ns/1ps
package spi_cmd_pkg;
  // byte index across one transaction: command + up to 8 tx + up to 15 rx
  localparam int IDX_W = 5;

  localparam logic [3:0] ADDR_OPC  = 4'h0;
  localparam logic [3:0] ADDR_CNT  = 4'h1;
  localparam logic [3:0] ADDR_CTL  = 4'h2;
  localparam logic [3:0] ADDR_STS  = 4'h3;
  localparam logic [3:0] ADDR_DATA = 4'hC;
  localparam logic [3:0] ADDR_PTR  = 4'hD;

  typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_HIGH} shiftState_t;

  typedef struct packed {
    logic             load;     // load next outgoing byte
    logic             shift;    // advance outgoing byte by one bit
    logic             sample;   // capture MISO
    logic             store;    // write captured byte to FIFO
    logic [IDX_W-1:0] loadIdx;  // transaction byte index being loaded
    logic [IDX_W-1:0] storeIdx; // transaction byte index being stored
  } ctlStrobes_t;
endpackage

// File: rtl/spi_cmd_dp.sv
`timescale 1ns/1ps
module spi_cmd_dp
  import spi_cmd_pkg::*;
#(
  parameter int FIFO_DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       regAddr,
  input  logic             regWrEn,
  input  logic [7:0]       regWrData,
  input  logic             regRdEn,
  output logic [7:0]       regRdData,
  input  logic             busy,
  input  ctlStrobes_t      strobes,
  input  logic             spiMiso,
  output logic             spiMosi,
  output logic             startReq,
  output logic [IDX_W-1:0] txLen,
  output logic [IDX_W-1:0] rxLen
);
  localparam int PTR_W = $clog2(FIFO_DEPTH);
  localparam logic [IDX_W-1:0] DEPTH_L = IDX_W'(FIFO_DEPTH);

  logic [7:0]       opcodeQ;
  logic [7:0]       countQ;
  logic [7:0]       fifoMem [FIFO_DEPTH];
  logic [PTR_W-1:0] ptrQ;
  logic [7:0]       txShift;
  logic [7:0]       rxShift;

  logic wrOpc, wrCnt, wrData, rdData, ptrClr;
  logic [IDX_W-1:0] txField, rxField, loadM1, storeM1;
  logic [PTR_W-1:0] loadSel, storeSel;
  logic             loadFromFifo;

  assign wrOpc    = regWrEn && (regAddr == ADDR_OPC) && !busy;
  assign wrCnt    = regWrEn && (regAddr == ADDR_CNT) && !busy;
  assign wrData   = regWrEn && (regAddr == ADDR_DATA) && !busy;
  assign rdData   = regRdEn && (regAddr == ADDR_DATA);
  assign ptrClr   = regWrEn && (regAddr == ADDR_CTL) && regWrData[4];
  assign startReq = regWrEn && (regAddr == ADDR_CTL) && regWrData[0] && !busy;

  // count decoding: clamp tx to FIFO depth, off-by-one rx when tx is empty
  assign txField = IDX_W'(countQ[3:0]);
  assign rxField = IDX_W'(countQ[7:4]);
  assign txLen   = (txField > DEPTH_L) ? DEPTH_L : txField;
  assign rxLen   = (txField != '0) ? rxField :
                   (rxField != '0) ? rxField - 1'b1 : '0;

  assign loadM1       = strobes.loadIdx - 1'b1;
  assign storeM1      = strobes.storeIdx - 1'b1;
  assign loadSel      = loadM1[PTR_W-1:0];
  assign storeSel     = storeM1[PTR_W-1:0];
  assign loadFromFifo = (strobes.loadIdx != '0) && (strobes.loadIdx <= txLen);

  assign spiMosi = txShift[7];

  always_ff @(posedge clk) begin
    if (rst) begin
      opcodeQ <= '0;
      countQ  <= '0;
      ptrQ    <= '0;
      txShift <= '0;
      rxShift <= '0;
      for (int i = 0; i < FIFO_DEPTH; i++) fifoMem[i] <= '0;
    end else begin
      if (wrOpc) opcodeQ <= regWrData;
      if (wrCnt) countQ  <= regWrData;
      if (ptrClr) ptrQ <= '0;
      else if (wrData || rdData) ptrQ <= ptrQ + 1'b1;
      if (wrData) fifoMem[ptrQ] <= regWrData;
      if (strobes.store) fifoMem[storeSel] <= rxShift;
      if (strobes.load) begin
        if (strobes.loadIdx == '0) txShift <= opcodeQ;
        else if (loadFromFifo)     txShift <= fifoMem[loadSel];
        else                       txShift <= '0;
      end else if (strobes.shift) begin
        txShift <= {txShift[6:0], 1'b0};
      end
      if (strobes.sample) rxShift <= {rxShift[6:0], spiMiso};
    end
  end

  always_comb begin
    case (regAddr)
      ADDR_OPC:  regRdData = opcodeQ;
      ADDR_CNT:  regRdData = countQ;
      ADDR_CTL:  regRdData = {7'b0, busy};
      ADDR_STS:  regRdData = {busy, 7'b0};
      ADDR_DATA: regRdData = fifoMem[ptrQ];
      ADDR_PTR:  regRdData = 8'(ptrQ);
      default:   regRdData = '0;
    endcase
  end
endmodule

// File: rtl/spi_cmd_ctrl.sv
`timescale 1ns/1ps
module spi_cmd_ctrl
  import spi_cmd_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             startReq,
  input  logic [IDX_W-1:0] txLen,
  input  logic [IDX_W-1:0] rxLen,
  output ctlStrobes_t      strobes,
  output logic             busy,
  output logic             spiCsN,
  output logic             spiSclk
);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

  shiftState_t      state;
  logic [DIV_W-1:0] divCnt;
  logic [2:0]       bitCnt;
  logic [IDX_W-1:0] byteCnt;
  logic [IDX_W-1:0] lastByte;

  logic phaseEnd, byteEnd, finalByte;

  assign phaseEnd  = (divCnt == DIV_LAST);
  assign byteEnd   = (state == ST_HIGH) && phaseEnd && (bitCnt == 3'd7);
  assign finalByte = (byteCnt == lastByte);
  assign busy      = (state != ST_IDLE);

  always_comb begin
    strobes          = '0;
    strobes.load     = ((state == ST_IDLE) && startReq) || (byteEnd && !finalByte);
    strobes.loadIdx  = (state == ST_IDLE) ? '0 : byteCnt + 1'b1;
    strobes.sample   = (state == ST_LOW) && phaseEnd;
    strobes.shift    = (state == ST_HIGH) && phaseEnd && (bitCnt != 3'd7);
    strobes.store    = byteEnd && (byteCnt > txLen);
    strobes.storeIdx = byteCnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      divCnt   <= '0;
      bitCnt   <= '0;
      byteCnt  <= '0;
      lastByte <= '0;
      spiCsN   <= 1'b1;
      spiSclk  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (startReq) begin
          state    <= ST_LOW;
          spiCsN   <= 1'b0;
          spiSclk  <= 1'b0;
          divCnt   <= '0;
          bitCnt   <= '0;
          byteCnt  <= '0;
          lastByte <= txLen + rxLen;
        end
        ST_LOW: if (phaseEnd) begin
          spiSclk <= 1'b1;
          divCnt  <= '0;
          state   <= ST_HIGH;
        end else begin
          divCnt <= divCnt + 1'b1;
        end
        ST_HIGH: if (phaseEnd) begin
          spiSclk <= 1'b0;
          divCnt  <= '0;
          if (bitCnt == 3'd7) begin
            bitCnt <= '0;
            if (finalByte) begin
              state  <= ST_IDLE;
              spiCsN <= 1'b1;
            end else begin
              byteCnt <= byteCnt + 1'b1;
              state   <= ST_LOW;
            end
          end else begin
            bitCnt <= bitCnt + 1'b1;
            state  <= ST_LOW;
          end
        end else begin
          divCnt <= divCnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_cmd_engine.sv
`timescale 1ns/1ps
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int CLK_DIV    = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] regAddr,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  input  logic       regRdEn,
  output logic [7:0] regRdData,
  output logic       spiCsN,
  output logic       spiSclk,
  output logic       spiMosi,
  input  logic       spiMiso
);
  ctlStrobes_t      strobes;
  logic             busy;
  logic             startReq;
  logic [IDX_W-1:0] txLen;
  logic [IDX_W-1:0] rxLen;

  spi_cmd_dp #(.FIFO_DEPTH(FIFO_DEPTH)) dp (
    .clk(clk), .rst(rst), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdEn(regRdEn), .regRdData(regRdData),
    .busy(busy), .strobes(strobes), .spiMiso(spiMiso), .spiMosi(spiMosi),
    .startReq(startReq), .txLen(txLen), .rxLen(rxLen)
  );

  spi_cmd_ctrl #(.CLK_DIV(CLK_DIV)) ctrl (
    .clk(clk), .rst(rst), .startReq(startReq), .txLen(txLen), .rxLen(rxLen),
    .strobes(strobes), .busy(busy), .spiCsN(spiCsN), .spiSclk(spiSclk)
  );
endmodule

// File: rtl/spi_cmd_chk.sv
`timescale 1ns/1ps
module spi_cmd_chk
  import spi_cmd_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic [3:0] regAddr,
  input logic       regWrEn,
  input logic [7:0] regWrData,
  input logic [7:0] regRdData,
  input logic       busy,
  input logic       spiCsN,
  input logic       spiSclk,
  input logic       spiMosi
);
  // R8
  sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
    spiCsN |-> !spiSclk);

  // R8
  mosi_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!spiCsN && spiSclk) |-> $stable(spiMosi));

  // R3
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && regWrEn && regAddr == ADDR_CTL && regWrData[0]) |=> (busy && !spiCsN));

  // R3
  exec_read_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && regAddr == ADDR_CTL) |-> regRdData[0]);

  // R4
  ptr_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (regWrEn && regAddr == ADDR_CTL && regWrData[4]) |=>
      (regAddr != ADDR_PTR || regRdData == 8'h00));
endmodule

bind spi_cmd_engine spi_cmd_chk chkInst (
  .clk(clk), .rst(rst), .regAddr(regAddr), .regWrEn(regWrEn),
  .regWrData(regWrData), .regRdData(regRdData), .busy(busy),
  .spiCsN(spiCsN), .spiSclk(spiSclk), .spiMosi(spiMosi)
);

// File: tb/tb_spi_cmd_engine.sv
`timescale 1ns/1ps
module tb_spi_cmd_engine;
  localparam int DIV = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] regAddr = '0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic       regRdEn = 1'b0;
  logic [7:0] regRdData;
  logic       spiCsN, spiSclk, spiMosi;
  logic       spiMiso = 1'b0;

  spi_cmd_engine #(.FIFO_DEPTH(8), .CLK_DIV(DIV)) dut (
    .clk(clk), .rst(rst), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdEn(regRdEn), .regRdData(regRdData),
    .spiCsN(spiCsN), .spiSclk(spiSclk), .spiMosi(spiMosi), .spiMiso(spiMiso)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] respByte(input int n);
    return 8'(n * 37 + 90);
  endfunction

  // ---------------- reference model ----------------
  logic [7:0] mOp = '0, mCnt = '0;
  logic [7:0] mFifo [8];
  int mPtr = 0, mBusyCnt = 0, mTx = 0, mRx = 0;
  logic [7:0] expMosi [$];
  bit mIdle;

  always @(posedge clk) begin
    if (rst) begin
      mOp = '0; mCnt = '0; mPtr = 0; mBusyCnt = 0;
      for (int i = 0; i < 8; i++) mFifo[i] = '0;
    end else begin
      mIdle = (mBusyCnt == 0);
      if (!mIdle) begin
        mBusyCnt--;
        if (mBusyCnt == 0)
          for (int j = 0; j < mRx; j++) mFifo[(mTx + j) % 8] = respByte(1 + mTx + j);
      end
      if (regWrEn) begin
        case (regAddr)
          4'h0: if (mIdle) mOp = regWrData;
          4'h1: if (mIdle) mCnt = regWrData;
          4'h2: begin
            if (regWrData[4]) mPtr = 0;
            if (regWrData[0] && mIdle) begin
              int tf, rf;
              tf = int'(mCnt[3:0]);
              rf = int'(mCnt[7:4]);
              mTx = (tf > 8) ? 8 : tf;
              mRx = (tf != 0) ? rf : ((rf > 0) ? rf - 1 : 0);
              mBusyCnt = 16 * DIV * (1 + mTx + mRx);
              expMosi.delete();
              expMosi.push_back(mOp);
              for (int k = 0; k < mTx; k++) expMosi.push_back(mFifo[k]);
              for (int k = 0; k < mRx; k++) expMosi.push_back(8'h00);
            end
          end
          4'hC: if (mIdle) begin mFifo[mPtr] = regWrData; mPtr = (mPtr + 1) % 8; end
          default: ;
        endcase
      end
      if (regRdEn && regAddr == 4'hC) mPtr = (mPtr + 1) % 8;
    end
  end

  function automatic int modelRead(input logic [3:0] a);
    bit b;
    b = (mBusyCnt > 0);
    case (a)
      4'h0: return int'(mOp);
      4'h1: return int'(mCnt);
      4'h2: return b ? 1 : 0;
      4'h3: return b ? 8'h80 : 0;
      4'hC: return int'(mFifo[mPtr]);
      4'hD: return mPtr;
      default: return 0;
    endcase
  endfunction

  // per-clock comparison of chip select and SCLK against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk("R8 chip select window", int'(spiCsN), (mBusyCnt == 0) ? 1 : 0);
      if (spiCsN) chk("R8 sclk idle low", int'(spiSclk), 0);
    end
  end

  // ---------------- SPI slave ----------------
  int sbit = 0;
  logic [7:0] curByte = '0;
  logic [7:0] mosiBytes [$];
  logic [7:0] tmpB;

  always @(negedge spiCsN) begin
    sbit = 0;
    mosiBytes.delete();
    tmpB = respByte(0);
    spiMiso = tmpB[7];
  end
  always @(posedge spiSclk) if (!spiCsN) begin
    curByte = {curByte[6:0], spiMosi};
    sbit++;
    if (sbit % 8 == 0) mosiBytes.push_back(curByte);
  end
  always @(negedge spiSclk) if (!spiCsN) begin
    tmpB = respByte(sbit / 8);
    spiMiso = tmpB[7 - (sbit % 8)];
  end

  // ---------------- tasks ----------------
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdChk(input logic [3:0] a, input string req);
    regAddr = a; regRdEn = 1'b1;
    #1;
    chk(req, int'(regRdData), modelRead(a));
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic waitIdle();
    while (mBusyCnt > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic checkMosi(input string req);
    chk({req, " byte count"}, mosiBytes.size(), expMosi.size());
    for (int i = 0; i < expMosi.size() && i < mosiBytes.size(); i++)
      chk(req, int'(mosiBytes[i]), int'(expMosi[i]));
  endtask

  task automatic dumpFifo(input string req);
    wr(4'h2, 8'h10);
    for (int i = 0; i < 8; i++) rdChk(4'hC, req);
  endtask

  task automatic runTxn(input logic [7:0] op, input logic [7:0] cnt, input string req);
    wr(4'h0, op);
    wr(4'h1, cnt);
    wr(4'h2, 8'h01);
    rdChk(4'h2, "R3 execute reads 1");
    rdChk(4'h3, "R3 busy flag");
    waitIdle();
    rdChk(4'h2, "R3 execute cleared");
    rdChk(4'h3, "R3 busy cleared");
    checkMosi(req);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    for (int i = 0; i < 8; i++) mFifo[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    chk("R10 chip select high", int'(spiCsN), 1);
    chk("R10 sclk low", int'(spiSclk), 0);
    rdChk(4'h0, "R10 command reg");
    rdChk(4'h1, "R10 count reg");
    rdChk(4'h2, "R10 control reg");
    rdChk(4'h3, "R10 status reg");
    rdChk(4'hD, "R10 pointer");
    rdChk(4'hC, "R10 fifo");
    rdChk(4'h7, "R5 unused address reads 0");

    // R5 fill FIFO, pointer wraps after eight writes
    wr(4'h2, 8'h10);
    for (int i = 0; i < 8; i++) wr(4'hC, 8'(8'h11 * (i + 1)));
    rdChk(4'hD, "R5 pointer wrap");

    // R1 R2 R6: tx 3, rx 2
    runTxn(8'h9F, 8'h23, "R1 R6 mosi stream tx3 rx2");
    rdChk(4'h1, "R2 count readback");
    dumpFifo("R6 fifo after tx3 rx2");

    // R7: tx 0, rx field 4 gives three bytes
    runTxn(8'h03, 8'h40, "R7 mosi stream tx0 rx4");
    dumpFifo("R7 fifo after tx0 rx4");

    // R7: tx 0, rx field 0 gives command only
    runTxn(8'hAB, 8'h00, "R7 command only");

    // R2: tx field 12 clamps to 8, one rx byte into entry 0
    runTxn(8'h5C, 8'h1C, "R2 clamped tx");
    dumpFifo("R2 fifo after clamped tx");

    // R6: receive bytes wrap past entry 7
    runTxn(8'h0B, 8'h46, "R6 wrap tx6 rx4");
    dumpFifo("R6 fifo after wrap");

    // R9: writes during busy are ignored
    wr(4'h2, 8'h10);
    wr(4'hC, 8'hC1);
    wr(4'h0, 8'h3B);
    wr(4'h1, 8'h21);
    wr(4'h2, 8'h01);
    wr(4'h0, 8'h55);
    wr(4'h1, 8'h77);
    wr(4'hC, 8'hEE);
    wr(4'h2, 8'h01);
    rdChk(4'hD, "R9 pointer held during busy write");
    waitIdle();
    checkMosi("R9 stream unaffected by busy writes");
    rdChk(4'h0, "R9 command write ignored");
    rdChk(4'h1, "R9 count write ignored");
    dumpFifo("R9 fifo write ignored");

    // R4 pointer readback and clear
    wr(4'h2, 8'h10);
    for (int i = 0; i < 3; i++) wr(4'hC, 8'(i));
    rdChk(4'hD, "R4 pointer reads 3");
    wr(4'h2, 8'h10);
    rdChk(4'hD, "R4 pointer cleared");
    rdChk(4'hC, "R5 data at cleared pointer");
    rdChk(4'hD, "R5 pointer advanced by read");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule